// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-target SPI master that a processor runs through five 32-bit registers on a simple synchronous bus. Writes are taken on the clock edge when `reg_wr` is high. Reads are combinational from `reg_addr`.

Software first sets the word width and the clock prescale. It then asserts the chip select through the control register and writes a word to the transmit register. That write starts one full-duplex transfer of 8 or 16 bits in SPI mode 0, most significant bit first. When the last bit is done, the received word is placed in the receive register and a completion flag is set. The flag stays set until software writes zero to the cause register.

The serial clock is derived from the system clock. Its period is an even number of system clocks, from 4 to 30, set by the prescale field.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `mosi` is 0, and the control, configuration, receive and cause registers all read 0.
- R2: Control register (offset 0x00) bit 0 reads back as written, and `cs_n` is its inverse.
- R3: Configuration register (offset 0x04) keeps bits 5:0 and reads every other bit as 0. The control register reads 0 above bit 0. The transmit register (offset 0x08) and unmapped offsets read 0.
- R4: With prescale field P (configuration bits 4:0), define the half period H = P − 0x10, and H = 2 when P < 0x12. The completion flag becomes readable exactly 2·H·W clock edges after the edge that accepts the transmit write, where W is the word width.
- R5: `sck` idles low and makes exactly W rising edges per transfer. `mosi` presents the word MSB first, stable at each rising edge, and `miso` is sampled on the rising edge.
- R6: Configuration bit 5 selects the width: set means 16-bit words from `wdata[15:0]`, clear means 8-bit words from `wdata[7:0]`. Higher write bits are ignored.
- R7: The cause register (offset 0x10) reads 1 once a transfer completes. A write of zero clears it. A nonzero write leaves it unchanged.
- R8: The receive register (offset 0x0C) returns the last completed word in its low W bits with zeros above. While a transfer runs, it returns the previous word.
- R9: A transmit write while a transfer is running is ignored. It does not change the shifted word, the duration or the number of `sck` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Wrong divider or bit-counter state shows up as a changed completion time and a wrong count of `sck` rising edges. Both are visible within the same word. A mistake in shift-register alignment appears as a rotated or truncated word. This shows on `mosi` as captured by the bench's slave model, and in the receive register once the flag is set. Mistakes in flag or receive-register capture show at the first register read after a transfer or a clear. Accepting a transmit write while busy would show as a changed word or an extra burst of clock edges after completion.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int WORD_MAX = 16;
  localparam int WORD_MIN = 8;
  localparam int PRE_W    = 5;
  localparam int BIT_CW   = $clog2(WORD_MAX);

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 5'h10;

  // Prescale encoding: half period = field - base, floored at PRE_MIN_HALF.
  localparam logic [PRE_W-1:0] PRE_BASE     = 5'h10;
  localparam logic [PRE_W-1:0] PRE_MIN_HALF = 5'd2;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_CFG, SEL_TX, SEL_RX, SEL_CAUSE, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] half_m1,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == half_m1);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide,
  input  logic [PRE_W-1:0]    prescale,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                miso,
  input  logic                tick,
  output logic [PRE_W-1:0]    half_m1,
  output logic                busy,
  output logic                sck,
  output logic                mosi,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_word
);
  localparam int PAD = WORD_MAX - WORD_MIN;

  logic                busy_q, busy_d;
  logic                sck_q, sck_d;
  logic                wide_q, wide_d;
  logic [BIT_CW-1:0]   bit_q, bit_d;
  logic [PRE_W-1:0]    hm1_q, hm1_d;
  logic [WORD_MAX-1:0] txsh_q, txsh_d;
  logic [WORD_MAX-1:0] rxsh_q, rxsh_d;
  logic [BIT_CW-1:0]   last_bit;
  logic [PRE_W-1:0]    half_sel;

  always_comb begin
    last_bit = wide_q ? BIT_CW'(WORD_MAX - 1) : BIT_CW'(WORD_MIN - 1);
    half_sel = (prescale < (PRE_BASE + PRE_MIN_HALF)) ? PRE_MIN_HALF
                                                      : (prescale - PRE_BASE);
    done     = busy_q && tick && sck_q && (bit_q == last_bit);

    busy_d = busy_q;
    sck_d  = sck_q;
    wide_d = wide_q;
    bit_d  = bit_q;
    hm1_d  = hm1_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;

    if (!busy_q && start) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      wide_d = wide;
      bit_d  = '0;
      hm1_d  = half_sel - 1'b1;
      txsh_d = wide ? tx_word : {tx_word[WORD_MIN-1:0], {PAD{1'b0}}};
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_d  = 1'b1;
        rxsh_d = {rxsh_q[WORD_MAX-2:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d  = bit_q + 1'b1;
          txsh_d = {txsh_q[WORD_MAX-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      wide_q <= 1'b0;
      bit_q  <= '0;
      hm1_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      wide_q <= wide_d;
      bit_q  <= bit_d;
      hm1_q  <= hm1_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
    end
  end

  assign half_m1 = hm1_q;
  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & txsh_q[WORD_MAX-1];
  assign rx_word = wide_q ? rxsh_q : {{PAD{1'b0}}, rxsh_q[WORD_MIN-1:0]};

  // R5
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R4
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck_q));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                busy,
  input  logic                done,
  input  logic [WORD_MAX-1:0] rx_word,
  output logic [DATA_W-1:0]   rdata,
  output logic                cs_on,
  output logic                wide,
  output logic [PRE_W-1:0]    prescale,
  output logic                start,
  output logic [WORD_MAX-1:0] tx_word
);
  reg_sel_e            sel;
  logic                cs_q, cs_d;
  logic                wide_q, wide_d;
  logic [PRE_W-1:0]    pre_q, pre_d;
  logic                flag_q, flag_d;
  logic [WORD_MAX-1:0] rx_q, rx_d;
  logic                clr_req;

  always_comb begin
    unique case (addr)
      OFF_CTRL:  sel = SEL_CTRL;
      OFF_CFG:   sel = SEL_CFG;
      OFF_TX:    sel = SEL_TX;
      OFF_RX:    sel = SEL_RX;
      OFF_CAUSE: sel = SEL_CAUSE;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    clr_req = wr && (sel == SEL_CAUSE) && (wdata == '0);
    cs_d   = (wr && sel == SEL_CTRL) ? wdata[0] : cs_q;
    wide_d = (wr && sel == SEL_CFG)  ? wdata[PRE_W] : wide_q;
    pre_d  = (wr && sel == SEL_CFG)  ? wdata[PRE_W-1:0] : pre_q;
    flag_d = done ? 1'b1 : (clr_req ? 1'b0 : flag_q);
    rx_d   = done ? rx_word : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      wide_q <= 1'b0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      cs_q   <= cs_d;
      wide_q <= wide_d;
      pre_q  <= pre_d;
      flag_q <= flag_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL:  rdata[0] = cs_q;
      SEL_CFG:   rdata[PRE_W:0] = {wide_q, pre_q};
      SEL_RX:    rdata[WORD_MAX-1:0] = rx_q;
      SEL_CAUSE: rdata[0] = flag_q;
      default:   rdata = '0;
    endcase
  end

  assign cs_on    = cs_q;
  assign wide     = wide_q;
  assign prescale = pre_q;
  assign start    = wr && (sel == SEL_TX) && !busy;
  assign tx_word  = wdata[WORD_MAX-1:0];

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && clr_req) |=> !flag_q);

  // R8
  rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(rx_q));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                cs_on, wide, start, busy, done, tick;
  logic [PRE_W-1:0]    prescale, half_m1;
  logic [WORD_MAX-1:0] tx_word, rx_word;

  spi_host_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .done     (done),
    .rx_word  (rx_word),
    .rdata    (reg_rdata),
    .cs_on    (cs_on),
    .wide     (wide),
    .prescale (prescale),
    .start    (start),
    .tx_word  (tx_word)
  );

  spi_host_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (busy),
    .half_m1 (half_m1),
    .tick    (tick)
  );

  spi_host_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .wide     (wide),
    .prescale (prescale),
    .tx_word  (tx_word),
    .miso     (miso),
    .tick     (tick),
    .half_m1  (half_m1),
    .busy     (busy),
    .sck      (sck),
    .mosi     (mosi),
    .done     (done),
    .rx_word  (rx_word)
  );

  assign cs_n = ~cs_on;
endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cs_n, sck, mosi, miso;

  spi_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // slave model: drives on falling sck, samples on rising sck
  logic [15:0] s_tx = '0;
  logic [15:0] s_rx = '0;
  int          rises = 0;
  assign miso = s_tx[15];
  always @(negedge sck) s_tx = {s_tx[14:0], 1'b0};
  always @(posedge sck) begin
    s_rx = {s_rx[14:0], mosi};
    rises++;
  end

  typedef struct {
    logic [15:0] rx;
    logic [15:0] mo;
    int          cyc;
    int          edges;
    logic [31:0] rx_mid;
    bit          poke;
    string       tag;
  } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // monitor: compares results against expectations as they arrive
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        check(a.cyc == e.cyc, {"R4 cycles ", e.tag}, a.cyc, e.cyc);
        check(a.edges == e.edges, {"R5 sck edges ", e.tag}, a.edges, e.edges);
        check(a.mo == e.mo, {"R5/R6 mosi word ", e.tag}, a.mo, e.mo);
        check(a.rx == e.rx, {"R8 rx word ", e.tag}, a.rx, e.rx);
        if (e.poke) begin
          check(a.rx_mid == e.rx_mid, {"R8 rx during transfer ", e.tag},
                a.rx_mid, e.rx_mid);
        end
      end
    end
  end

  logic [15:0] last_rx = '0;

  task automatic do_xfer(logic [5:0] cfg, logic [31:0] txd, logic [15:0] slv,
                         bit poke, string tag);
    item_t e, a;
    logic [31:0] d;
    int h, w, n;
    bit got;
    w = cfg[5] ? 16 : 8;
    h = (cfg[4:0] < 5'h12) ? 2 : int'(cfg[4:0]) - 16;
    e.cyc = 2 * h * w; e.edges = w; e.poke = poke; e.tag = tag;
    e.mo = cfg[5] ? txd[15:0] : {8'h00, txd[7:0]};
    e.rx = cfg[5] ? slv : {8'h00, slv[7:0]};
    e.rx_mid = {16'h0, last_rx};
    exp_q.push_back(e);
    a.poke = poke; a.tag = tag; a.rx_mid = '0;
    bus_write(5'h04, {26'h0, cfg});
    @(negedge clk);
    s_tx = cfg[5] ? slv : {slv[7:0], 8'h00};
    s_rx = '0;
    rises = 0;
    bus_write(5'h08, txd);
    n = 0; got = 0;
    while (!got && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = 5'h10;
      #1 got = (reg_rdata != 0);
      if (!got && poke && n == 3) begin
        reg_addr = 5'h0C;
        #1 a.rx_mid = reg_rdata;
        reg_addr = 5'h08; reg_wdata = ~txd; reg_wr = 1'b1;
      end
    end
    a.cyc = n;
    repeat (40) @(posedge clk);
    a.edges = rises;
    a.mo = cfg[5] ? s_rx : {8'h00, s_rx[7:0]};
    bus_read(5'h0C, d);
    a.rx = d[15:0];
    check(d[31:16] == 16'h0, {"R8 rx upper zero ", tag}, d, {16'h0, d[15:0]});
    last_rx = e.rx;
    act_q.push_back(a);
    bus_read(5'h10, d);
    check(d == 32'h1, {"R7 flag set ", tag}, d, 32'h1);
    bus_write(5'h10, 32'h5);
    bus_read(5'h10, d);
    check(d == 32'h1, {"R7 nonzero write keeps flag ", tag}, d, 32'h1);
    bus_write(5'h10, 32'h0);
    bus_read(5'h10, d);
    check(d == 32'h0, {"R7 zero write clears ", tag}, d, 32'h0);
    check(sck == 1'b0, {"R5 sck idle ", tag}, sck, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    // R1 reset state
    @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(mosi == 1'b0, "R1 mosi", mosi, 0);
    bus_read(5'h00, d); check(d == 0, "R1 ctrl", d, 0);
    bus_read(5'h04, d); check(d == 0, "R1 cfg", d, 0);
    bus_read(5'h0C, d); check(d == 0, "R1 rx", d, 0);
    bus_read(5'h10, d); check(d == 0, "R1 cause", d, 0);
    // R2 chip select, R3 unused bits
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h00, d); check(d == 32'h1, "R2 ctrl readback", d, 1);
    check(cs_n == 1'b0, "R2 cs_n asserted", cs_n, 0);
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_read(5'h04, d); check(d == 32'h3F, "R3 cfg readback", d, 32'h3F);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h08, d); check(d == 0, "R3 tx reads zero", d, 0);
    bus_read(5'h14, d); check(d == 0, "R3 unmapped zero", d, 0);
    bus_read(5'h0C, d); check(d == 0, "R3 rx not writable", d, 0);
    // transfers (R4 R5 R6 R8 R9)
    do_xfer(6'h12, 32'h0000_00A5, 16'h003C, 0, "8b ratio4");
    do_xfer(6'h35, 32'hABCD_1234, 16'hBEEF, 1, "16b ratio10 busy-write R9");
    do_xfer(6'h1F, 32'h0000_03C7, 16'h0081, 1, "8b ratio30 busy-write R9");
    do_xfer(6'h03, 32'h0000_005A, 16'h00F0, 0, "8b clamp");
    do_xfer(6'h3F, 32'h0000_8001, 16'h7FFE, 0, "16b ratio30 R6");
    bus_write(5'h00, 32'h0);
    @(negedge clk);
    check(cs_n == 1'b1, "R2 cs_n released", cs_n, 1);
    wait (act_q.size() == 0);
    repeat (2) @(posedge clk);
    summary();
  end
endmodule